// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers eight hardware interrupt sources into one request line for a small CPU. There are two external pins and six internal event pulses: three timers, an interval tick, the watchdog and key scan. Each source has a latched pending flag and its own enable bit. The block offers the CPU the winning request together with a vector code. A software break request sits above all of them and cannot be masked. The block also holds the global interrupt-enable flag, and that flag gates every maskable source.

The external pins pass through a synchronizer, and a rising edge there sets the pending flag. The internal sources set their flags with a one-cycle pulse. When the CPU strobes `ack` while `irq` is high, the block runs a fixed sequence. In the accepting cycle it clears the global enable and the chosen flag. In the next cycle it asks the CPU to push its state, and it reports the global enable value that was current at acceptance. In the cycle after that, it presents the vector. Nesting needs software to set the global enable again inside the service routine. A return strobe reloads the global enable from the value that was popped.

Top module: `prio_irq_top`

## Requirements
- R1: After reset, all pending flags, all enable bits and the global enable read 0, the break request is not pending, and `irq`, `pushStb` and `vecValid` are 0.
- R2: A rising edge on `extPin[e]` sets flag bit e. The flag reads 1 three clock edges after the pin changes (two synchronizer stages, then detection). A pin held high sets the flag only once, and a falling edge sets nothing.
- R3: A one-cycle pulse on `hwPulse[j]` sets flag bit j+2 at the next edge. A set flag stays 1 until that request is accepted or software writes a 0 to it.
- R4: A write through `flagWrEn` loads all flag bits from `flagWrData`. A hardware set in the same cycle wins over a written 0.
- R5: While idle, `irq` is 1 when the global enable is 1 and at least one flag has its enable bit set. A pending flag whose enable bit is 0 never raises `irq`.
- R6: Among the enabled pending flags, the lowest index wins. While idle, `vecIdx` shows that index (0 to 7).
- R7: A `brkReq` pulse leaves a break request pending. The break request raises `irq` whatever the enables and the global enable are, it outranks every flag, and its vector code is 8.
- R8: When `ack` is high while `irq` is 1, then at the next edge the global enable reads 0. The accepted flag (or the break request) is cleared, and every other flag is left as it was.
- R9: In the cycle after acceptance, `pushStb` is 1 and `pushedI` carries the global enable value from the accepting cycle. In the cycle after that, `vecValid` is 1 and `vecIdx` holds the accepted code. `irq` stays 0 through both cycles.
- R10: `ack` while `irq` is 0 has no effect. No sequence starts, and no flag changes.
- R11: After an acceptance, enabled pending flags do not raise `irq` until software sets the global enable again.
- R12: `retiStb` loads the global enable from `retiI`.
- R13: `setI` sets the global enable and `clrI` clears it, and `clrI` wins when both are high. Clearing on acceptance wins over `setI` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extPin | input | NUM_EXT | Asynchronous external interrupt pins |
| hwPulse | input | 6 | Single-cycle set pulses from the internal sources |
| brkReq | input | 1 | Software break request pulse |
| flagWrEn | input | 1 | Write strobe for the pending flags |
| flagWrData | input | 8 | Pending flag write value |
| enWrEn | input | 1 | Write strobe for the enable bits |
| enWrData | input | 8 | Enable bit write value |
| setI | input | 1 | Set the global enable |
| clrI | input | 1 | Clear the global enable |
| retiStb | input | 1 | Return strobe: reload the global enable |
| retiI | input | 1 | Popped global enable value |
| ack | input | 1 | CPU accepts the offered request |
| irq | output | 1 | Request to the CPU |
| vecIdx | output | 4 | Vector code: 0-7 for sources, 8 for break |
| pushStb | output | 1 | Push PC and status strobe |
| pushedI | output | 1 | Global enable value at acceptance |
| vecValid | output | 1 | Vector code valid strobe |
| flagOut | output | 8 | Current pending flags |
| enOut | output | 8 | Current enable bits |
| iFlagOut | output | 1 | Current global enable |

## Verification
The bench sweeps all 256 pending patterns and all 256 enable masks and compares against the lowest set bit. A reversed or off-by-one priority encoder shows up there as a wrong vector code. It checks the pin path before and on the third edge, so a synchronizer that is too short or too long is caught. It also holds the pin high and then drops it, which catches level or falling-edge triggering. Races in the same cycle get their own checks: a hardware set against a written 0, and `setI` against acceptance. These catch a design where the wrong side wins. The break request is accepted while flags are pending. This exposes a controller that clears a hardware flag at the same time, or that lets the break request be masked.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  parameter int SRC_N = 8;
  localparam int IDX_W = $clog2(SRC_N);
  localparam int VEC_W = IDX_W + 1;
  localparam logic [VEC_W-1:0] BRK_VEC = VEC_W'(SRC_N);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VECT = 2'd2
  } seqState_e;

  // Strobes raised by the control in the accepting cycle
  typedef struct packed {
    logic             clrI;
    logic             clrBrk;
    logic [SRC_N-1:0] clrMask;
  } ackStrobe_t;
endpackage

// File: rtl/prio_irq_dpath.sv
module prio_irq_dpath
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int HW_N       = SRC_N - NUM_EXT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [HW_N-1:0]  hwPulse,
  input  logic             brkReq,
  input  logic             flagWrEn,
  input  logic [SRC_N-1:0] flagWrData,
  input  logic             enWrEn,
  input  logic [SRC_N-1:0] enWrData,
  input  logic             setI,
  input  logic             clrI,
  input  logic             retiStb,
  input  logic             retiI,
  input  ackStrobe_t       strb,
  output logic             iFlag,
  output logic             brkPend,
  output logic             anyReq,
  output logic [IDX_W-1:0] winIdx,
  output logic [SRC_N-1:0] flagOut,
  output logic [SRC_N-1:0] enOut
);
  logic [SRC_N-1:0]   flagQ, flagN, enQ, setVec, pendMask;
  logic [NUM_EXT-1:0] extRise;
  logic               iFlagQ, brkQ;

  // Edge qualification for each external pin
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    logic [SYNC_STAGES-1:0] shQ;
    logic                   lastQ;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shQ   <= '0;
        lastQ <= 1'b0;
      end else begin
        shQ   <= {shQ[SYNC_STAGES-2:0], extPin[e]};
        lastQ <= shQ[SYNC_STAGES-1];
      end
    end
    assign extRise[e] = shQ[SYNC_STAGES-1] & ~lastQ;
  end

  assign setVec = {hwPulse, extRise};

  always_comb begin
    flagN = flagWrEn ? flagWrData : flagQ;
    flagN = flagN & ~strb.clrMask;
    flagN = flagN | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      flagQ <= flagN;
      if (enWrEn) enQ <= enWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            iFlagQ <= 1'b0;
    else if (strb.clrI)    iFlagQ <= 1'b0;
    else if (retiStb)      iFlagQ <= retiI;
    else if (clrI)         iFlagQ <= 1'b0;
    else if (setI)         iFlagQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            brkQ <= 1'b0;
    else if (brkReq)       brkQ <= 1'b1;
    else if (strb.clrBrk)  brkQ <= 1'b0;
  end

  // Fixed priority: lowest index wins
  assign pendMask = flagQ & enQ;
  always_comb begin
    winIdx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pendMask[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyReq  = |pendMask;
  assign iFlag   = iFlagQ;
  assign brkPend = brkQ;
  assign flagOut = flagQ;
  assign enOut   = enQ;

  for (genvar b = 0; b < SRC_N; b++) begin : g_hold
    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flagQ[b] && !flagWrEn && !strb.clrMask[b]) |=> flagQ[b]);
  end

  // R13
  accept_clears_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrI |=> !iFlagQ);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             iFlag,
  input  logic             brkPend,
  input  logic             anyReq,
  input  logic [IDX_W-1:0] winIdx,
  output ackStrobe_t       strb,
  output logic             irq,
  output logic [VEC_W-1:0] vecIdx,
  output logic             pushStb,
  output logic             pushedI,
  output logic             vecValid
);
  seqState_e        stQ, stN;
  logic [VEC_W-1:0] capVecQ, candVec;
  logic             capIQ, take;

  assign irq     = (stQ == ST_IDLE) && (brkPend || (iFlag && anyReq));
  assign take    = irq && ack;
  assign candVec = brkPend ? BRK_VEC : {1'b0, winIdx};

  always_comb begin
    strb.clrI    = take;
    strb.clrBrk  = take && brkPend;
    strb.clrMask = '0;
    if (take && !brkPend) strb.clrMask[winIdx] = 1'b1;
  end

  always_comb begin
    stN = stQ;
    case (stQ)
      ST_IDLE: if (take) stN = ST_PUSH;
      ST_PUSH: stN = ST_VECT;
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stQ     <= ST_IDLE;
      capVecQ <= '0;
      capIQ   <= 1'b0;
    end else begin
      stQ <= stN;
      if (take) begin
        capVecQ <= candVec;
        capIQ   <= iFlag;
      end
    end
  end

  assign vecIdx   = (stQ == ST_IDLE) ? candVec : capVecQ;
  assign pushStb  = (stQ == ST_PUSH);
  assign pushedI  = capIQ;
  assign vecValid = (stQ == ST_VECT);

  // R8
  accept_starts_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> pushStb);
  // R9
  push_then_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pushStb |=> vecValid);
  // R9
  seq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, pushStb, vecValid}));
  // R10
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !pushStb && !vecValid && ack) |=> !pushStb);
endmodule

// File: rtl/prio_irq_top.sv
module prio_irq_top
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int HW_N       = SRC_N - NUM_EXT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [HW_N-1:0]  hwPulse,
  input  logic             brkReq,
  input  logic             flagWrEn,
  input  logic [SRC_N-1:0] flagWrData,
  input  logic             enWrEn,
  input  logic [SRC_N-1:0] enWrData,
  input  logic             setI,
  input  logic             clrI,
  input  logic             retiStb,
  input  logic             retiI,
  input  logic             ack,
  output logic             irq,
  output logic [VEC_W-1:0] vecIdx,
  output logic             pushStb,
  output logic             pushedI,
  output logic             vecValid,
  output logic [SRC_N-1:0] flagOut,
  output logic [SRC_N-1:0] enOut,
  output logic             iFlagOut
);
  ackStrobe_t       strb;
  logic             iFlag, brkPend, anyReq;
  logic [IDX_W-1:0] winIdx;

  prio_irq_dpath #(.NUM_EXT(NUM_EXT), .SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .hwPulse(hwPulse),
    .brkReq(brkReq), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .enWrEn(enWrEn), .enWrData(enWrData), .setI(setI), .clrI(clrI),
    .retiStb(retiStb), .retiI(retiI), .strb(strb), .iFlag(iFlag),
    .brkPend(brkPend), .anyReq(anyReq), .winIdx(winIdx),
    .flagOut(flagOut), .enOut(enOut)
  );

  prio_irq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .ack(ack), .iFlag(iFlag), .brkPend(brkPend),
    .anyReq(anyReq), .winIdx(winIdx), .strb(strb), .irq(irq),
    .vecIdx(vecIdx), .pushStb(pushStb), .pushedI(pushedI), .vecValid(vecValid)
  );

  assign iFlagOut = iFlag;
endmodule

// File: tb/prio_irq_top_tb_top.sv
module prio_irq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] extPin = '0;
  logic [5:0] hwPulse = '0;
  logic brkReq = 0, flagWrEn = 0, enWrEn = 0, setI = 0, clrI = 0;
  logic retiStb = 0, retiI = 0, ack = 0;
  logic [7:0] flagWrData = '0, enWrData = '0;
  logic irq, pushStb, pushedI, vecValid, iFlagOut;
  logic [3:0] vecIdx;
  logic [7:0] flagOut, enOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .hwPulse(hwPulse),
    .brkReq(brkReq), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .enWrEn(enWrEn), .enWrData(enWrData), .setI(setI), .clrI(clrI),
    .retiStb(retiStb), .retiI(retiI), .ack(ack), .irq(irq),
    .vecIdx(vecIdx), .pushStb(pushStb), .pushedI(pushedI),
    .vecValid(vecValid), .flagOut(flagOut), .enOut(enOut), .iFlagOut(iFlagOut)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowBit(int v);
    for (int i = 7; i >= 0; i--) if (((v >> i) & 1) == 1) lowBit = i;
    if (v == 0) lowBit = 0;
  endfunction

  task automatic wrFlags(logic [7:0] v);
    flagWrEn = 1; flagWrData = v; step(); flagWrEn = 0;
  endtask

  task automatic wrEn(logic [7:0] v);
    enWrEn = 1; enWrData = v; step(); enWrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    check("R1 flags", flagOut, 0);
    check("R1 enables", enOut, 0);
    check("R1 iflag", iFlagOut, 0);
    check("R1 irq", irq, 0);
    check("R1 push", pushStb, 0);
    check("R1 vecValid", vecValid, 0);
    rst_n = 1; step();

    // R3 internal pulses set and hold
    for (int j = 0; j < 6; j++) begin
      hwPulse = 6'(1 << j); step(); hwPulse = '0;
      check("R3 set", flagOut, 1 << (j + 2));
      step(); step(); step();
      check("R3 hold", flagOut, 1 << (j + 2));
      wrFlags(8'h00);
      check("R3 sw clear", flagOut, 0);
    end

    // R2 external pins: latency, once per level, falling ignored
    for (int e = 0; e < 2; e++) begin
      extPin = 2'(1 << e); step(); step();
      check("R2 not yet", flagOut, 0);
      step();
      check("R2 third edge", flagOut, 1 << e);
      wrFlags(8'h00);
      step(); step(); step(); step();
      check("R2 level once", flagOut, 0);
      extPin = '0;
      step(); step(); step(); step();
      check("R2 falling", flagOut, 0);
    end

    // R4 write, and hardware set beats written zero
    wrFlags(8'hA5);
    check("R4 write", flagOut, 8'hA5);
    flagWrEn = 1; flagWrData = 8'h00; hwPulse = 6'h01; step();
    flagWrEn = 0; hwPulse = '0;
    check("R4 hw wins", flagOut, 8'h04);

    // R5 R6 sweep pending patterns and enable masks
    setI = 1; step(); setI = 0;
    wrEn(8'hFF);
    for (int p = 0; p < 256; p++) begin
      wrFlags(8'(p));
      check("R5 irq sweep", irq, (p != 0) ? 1 : 0);
      if (p != 0) check("R6 vec sweep", vecIdx, lowBit(p));
    end
    wrFlags(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wrEn(8'(m));
      check("R5 enable mask", irq, (m != 0) ? 1 : 0);
      if (m != 0) check("R6 vec mask", vecIdx, lowBit(m));
    end
    wrEn(8'hFF);
    clrI = 1; step(); clrI = 0;
    check("R5 gated by I", irq, 0);

    // R7 break: unmasked, top priority, code 8; hardware flags untouched
    wrEn(8'h00);
    brkReq = 1; step(); brkReq = 0;
    check("R7 irq unmasked", irq, 1);
    check("R7 vec", vecIdx, 8);
    wrEn(8'hFF);
    check("R7 outranks", vecIdx, 8);
    ack = 1; step(); ack = 0;
    check("R9 brk push", pushStb, 1);
    check("R9 brk pushedI", pushedI, 0);
    check("R8 brk flags kept", flagOut, 8'hFF);
    step();
    check("R9 brk vecValid", vecValid, 1);
    check("R7 brk vec code", vecIdx, 8);
    step();
    check("R7 brk cleared", irq, 0);

    // R8 R9 R11 acceptance of source 3 with 5 also pending
    wrFlags(8'h28);
    setI = 1; step(); setI = 0;
    check("R6 pre accept", vecIdx, 3);
    ack = 1; step(); ack = 0;
    check("R8 I cleared", iFlagOut, 0);
    check("R8 flag cleared", flagOut, 8'h20);
    check("R9 push", pushStb, 1);
    check("R9 pushedI", pushedI, 1);
    check("R9 irq low push", irq, 0);
    step();
    check("R9 vecValid", vecValid, 1);
    check("R9 vec", vecIdx, 3);
    check("R9 push gone", pushStb, 0);
    step();
    check("R11 no nest", irq, 0);
    check("R9 done", vecValid, 0);
    setI = 1; step(); setI = 0;
    check("R11 nest after setI", irq, 1);
    check("R11 nest vec", vecIdx, 5);

    // R13 acceptance beats setI
    ack = 1; setI = 1; step(); ack = 0; setI = 0;
    check("R13 accept over setI", iFlagOut, 0);
    step(); step();

    // R10 ack while irq is 0
    wrFlags(8'h01);
    ack = 1; step(); ack = 0;
    check("R10 no push", pushStb, 0);
    check("R10 flags", flagOut, 1);
    step();
    check("R10 no vec", vecValid, 0);

    // R12 return strobe
    retiStb = 1; retiI = 1; step(); retiStb = 0;
    check("R12 reload 1", iFlagOut, 1);
    retiStb = 1; retiI = 0; step(); retiStb = 0;
    check("R12 reload 0", iFlagOut, 0);

    // R13 set and clear strobes
    setI = 1; step(); setI = 0;
    check("R13 set", iFlagOut, 1);
    setI = 1; clrI = 1; step(); setI = 0; clrI = 0;
    check("R13 clr wins", iFlagOut, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule